// File: doc/BRIEF.md
# External Pulse Timestamp Capture Unit

This block tags the receive sample stream with the arrival of an external synchronisation pulse, such as a once-per-second edge on a general-purpose input. It runs a free-running 64-bit sample counter. The counter advances on the sample-load strobe that the RF interface raises each time samples enter the receive buffer. It also reports a timestamp that the packet framer places in each packet header. While the pulse is high, the reported value is a snapshot taken at the pulse's rising edge, with its top bit set as a marker. Once the pulse drops, the live counter is reported again. The counter never pauses, so no time is lost.

The interface mode is decoded from the MIMO, DDR, pulse-mode and channel-enable controls. In single-channel DDR mode the counter steps two samples per strobe. In that mode the snapshot replaces the counter's low bit with the parity of a small tick counter, which counts clocks since the last strobe. This gives single-sample resolution. In all other modes the counter steps once per strobe and the snapshot is taken unchanged. Two devices driven by the same pulse can then be aligned in post-processing. Their first flagged stamps name the same instant.

Top module: `pps_stamp_capture`

## Requirements
- R1: `mode_out` is decoded from the synchronised controls, with the rules checked in this order. It is 2'b00 when MIMO is off and DDR is on. Otherwise it is 2'b01 when MIMO or pulse mode is on and both channel enables are set. Otherwise it is 2'b10 when MIMO or pulse mode is on and exactly one channel enable is set. Otherwise it is 2'b11.
- R2: The sample counter adds 2 on each clock edge that sees `smp_load` high while the mode is 2'b00, and adds 1 in any other mode. Otherwise it holds. It keeps counting while the pulse is held high.
- R3: The tick counter clears on a strobe edge and otherwise counts up by one per clock. It saturates at all-ones, which is 15 with the default 4-bit width.
- R4: While the synchronised pulse is low, `stamp_out` equals the live counter. After the pulse falls, `stamp_out` returns to the live counter value, with every strobe seen during the hold counted.
- R5: In mode 2'b00 the snapshot is {1, counter[62:1], tick[0]}.
- R6: In modes 2'b01, 2'b10 and 2'b11 the snapshot is {1, counter[62:0]}.
- R7: `pulse_in` passes through a two-flop synchroniser. The snapshot takes the counter and tick values present after the second edge. It appears on `stamp_out` after the third edge and stays frozen while the pulse stays high. After the pulse falls, `stamp_out` returns to live on the third edge.
- R8: In reset `stamp_out` is 0 and `mode_out` is 2'b11, because all synchronised controls reset to 0.
- R9: A control change reaches `mode_out` after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_load | input | 1 | Sample-load strobe from the RF interface |
| pulse_in | input | 1 | Asynchronous external synchronisation pulse |
| mimo_en | input | 1 | MIMO control (asynchronous) |
| ddr_en | input | 1 | DDR control (asynchronous) |
| pulse_mode_en | input | 1 | Pulse-interface mode control (asynchronous) |
| chan_en | input | 2 | Channel enables (asynchronous) |
| stamp_out | output | 64 | Live counter, or the flagged snapshot while the pulse is held |
| mode_out | output | 2 | Decoded interface mode |

## Verification
The bench takes snapshots in DDR mode at two pulse phases relative to the strobe, so the tick parity lands on both 0 and 1. It also takes one after a long strobe gap, where a wrapping tick counter would give the wrong low bit. It checks the cycle just before the snapshot shows up, which exposes an output mux that switches one cycle early and shows a stale snapshot. It checks that the stamp stays frozen while strobes keep arriving, and that the live value after release includes every strobe from the hold. A design that paused the counter during the hold would fail there. The mode cases include the ones where rule order matters: MIMO together with DDR, and DDR together with pulse mode.

// File: rtl/pps_stamp_pkg.sv
// Shared types for the pulse timestamp capture unit.
package pps_stamp_pkg;
    typedef enum logic [1:0] {
        MODE_SISO_DDR = 2'b00,
        MODE_DUAL     = 2'b01,
        MODE_SINGLE   = 2'b10,
        MODE_OTHER    = 2'b11
    } if_mode_e;
endpackage

// File: rtl/pps_bit_sync.sv
// Two-flop synchroniser, one independent chain per bit.
// Assumes each bit is a level that is slow compared with clk; no
// coherence between bits is promised.
module pps_bit_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        // Two-stage capture of bit i into the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_async[i];
                stab_q <= meta_q;
            end
        end
        assign q_sync[i] = stab_q;
    end
endmodule

// File: rtl/pps_mode_decode.sv
// Interface mode decode from the synchronised controls.
// The rules are tested in a fixed order; the first one that matches wins.
module pps_mode_decode
    import pps_stamp_pkg::*;
(
    input  logic       mimo,
    input  logic       ddr,
    input  logic       pmode,
    input  logic [1:0] chan,
    output if_mode_e   mode
);
    logic wide_path;
    assign wide_path = mimo | pmode;

    // Ordered rule selection.
    always_comb begin
        if (!mimo && ddr)                     mode = MODE_SISO_DDR;
        else if (wide_path && (&chan))        mode = MODE_DUAL;
        else if (wide_path && (^chan))        mode = MODE_SINGLE;
        else                                  mode = MODE_OTHER;
    end
endmodule

// File: rtl/pps_sample_clock.sv
// Free-running sample counter and saturating ticks-since-strobe counter.
// Assumes load is synchronous to clk. step2 selects an increment of two.
module pps_sample_clock #(
    parameter int CNT_W  = 64,
    parameter int TICK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step2,
    output logic [CNT_W-1:0]  cnt,
    output logic [TICK_W-1:0] since
);
    localparam logic [TICK_W-1:0] TICK_MAX = '1;

    logic [CNT_W-1:0] step;
    assign step = step2 ? CNT_W'(2) : CNT_W'(1);

    // Sample counter: advance on every strobe, never paused.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= cnt + step;
    end

    // Tick counter: clear on a strobe, otherwise count up to all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since <= '0;
        else if (load)              since <= '0;
        else if (since != TICK_MAX) since <= since + 1'b1;
    end
endmodule

// File: rtl/pps_stamp_capture.sv
// Top: synchronises the pulse and mode controls, decodes the mode, keeps
// the sample counter and swaps in a flagged snapshot while the pulse is high.
// Assumes smp_load is synchronous to clk and the pulse lasts many clocks.
module pps_stamp_capture
    import pps_stamp_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int TICK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_load,
    input  logic             pulse_in,
    input  logic             mimo_en,
    input  logic             ddr_en,
    input  logic             pulse_mode_en,
    input  logic [1:0]       chan_en,
    output logic [CNT_W-1:0] stamp_out,
    output logic [1:0]       mode_out
);
    localparam int SYNC_W = 6;

    logic [SYNC_W-1:0] sync_d, sync_q;
    logic              pulse_s, mimo_s, ddr_s, pmode_s;
    logic [1:0]        chan_s;
    logic              held_q;
    logic              rise;
    if_mode_e          mode;
    logic [CNT_W-1:0]  cnt;
    logic [TICK_W-1:0] since;
    logic [CNT_W-1:0]  snap_q;

    assign sync_d = {pulse_in, mimo_en, ddr_en, pulse_mode_en, chan_en};
    assign {pulse_s, mimo_s, ddr_s, pmode_s, chan_s} = sync_q;

    pps_bit_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sync_d),
        .q_sync  (sync_q)
    );

    pps_mode_decode u_mode (
        .mimo  (mimo_s),
        .ddr   (ddr_s),
        .pmode (pmode_s),
        .chan  (chan_s),
        .mode  (mode)
    );

    pps_sample_clock #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_clock (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (smp_load),
        .step2 (mode == MODE_SISO_DDR),
        .cnt   (cnt),
        .since (since)
    );

    assign rise = pulse_s & ~held_q;

    // Delayed pulse level: edge detect and output select.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= pulse_s;
    end

    // Snapshot on the synchronised rising edge, refined in DDR mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (rise) begin
            if (mode == MODE_SISO_DDR)
                snap_q <= {1'b1, cnt[CNT_W-2:1], since[0]};
            else
                snap_q <= {1'b1, cnt[CNT_W-2:0]};
        end
    end

    assign stamp_out = held_q ? snap_q : cnt;
    assign mode_out  = mode;
endmodule

// File: rtl/pps_stamp_capture_chk.sv
// Property checker for pps_stamp_capture, attached through bind.
module pps_stamp_capture_chk #(
    parameter int CNT_W  = 64,
    parameter int TICK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_load,
    input logic              held,
    input logic              mimo_s,
    input logic              ddr_s,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  cnt,
    input logic [TICK_W-1:0] since,
    input logic [CNT_W-1:0]  stamp_out
);
    AST_MODE_DDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!mimo_s && ddr_s) |-> (mode == 2'b00)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        smp_load |=> (cnt == $past(cnt) + (($past(mode) == 2'b00) ? CNT_W'(2) : CNT_W'(1)))); // R2
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_load |=> $stable(cnt)); // R2
    AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        smp_load |=> (since == '0)); // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> stamp_out[CNT_W-1]); // R6
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> $stable(stamp_out)); // R7
endmodule

bind pps_stamp_capture pps_stamp_capture_chk #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_load  (smp_load),
    .held      (held_q),
    .mimo_s    (mimo_s),
    .ddr_s     (ddr_s),
    .mode      (mode_out),
    .cnt       (cnt),
    .since     (since),
    .stamp_out (stamp_out)
);

// File: tb/pps_stamp_capture_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module pps_stamp_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_MAX   = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_load = 1'b0;
    logic        pulse_in = 1'b0;
    logic        mimo_en = 1'b0, ddr_en = 1'b0, pulse_mode_en = 1'b0;
    logic [1:0]  chan_en = 2'b00;
    logic [63:0] stamp_out;
    logic [1:0]  mode_out;

    int n_chk = 0;
    int n_bad = 0;
    int strobe_per = 0;
    int cyc = 0;

    // Reference model of the requirement-level counters (R2, R3).
    logic [63:0] m_cnt = '0;
    int          m_since = 0;
    int          m_step = 1;
    logic        m_ddr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pps_stamp_capture u_dut (
        .clk(clk), .rst_n(rst_n), .smp_load(smp_load), .pulse_in(pulse_in),
        .mimo_en(mimo_en), .ddr_en(ddr_en), .pulse_mode_en(pulse_mode_en),
        .chan_en(chan_en), .stamp_out(stamp_out), .mode_out(mode_out)
    );

    // Strobe generator, driven on the falling edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        smp_load <= (strobe_per != 0) && ((cyc % strobe_per) == 0);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0;
            m_since <= 0;
        end else if (smp_load) begin
            m_cnt <= m_cnt + 64'(m_step);
            m_since <= 0;
        end else if (m_since < TICK_MAX) begin
            m_since <= m_since + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic mi, input logic dd, input logic pm, input logic [1:0] ch);
        strobe_per = 0;
        @(negedge clk);
        mimo_en = mi; ddr_en = dd; pulse_mode_en = pm; chan_en = ch;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R8 stamp in reset", stamp_out, 64'd0);
        check("R8 mode in reset", 64'(mode_out), 64'd3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_modes;
        // R9: control change visible after exactly two edges
        strobe_per = 0;
        @(negedge clk);
        mimo_en = 1'b0; ddr_en = 1'b1; pulse_mode_en = 1'b0; chan_en = 2'b01;
        @(negedge clk);
        check("R9 mode after one edge", 64'(mode_out), 64'd3);
        @(negedge clk);
        check("R9 mode after two edges", 64'(mode_out), 64'd0);
        set_mode(1'b1, 1'b1, 1'b0, 2'b11);
        check("R1 mimo+ddr dual", 64'(mode_out), 64'd1);
        set_mode(1'b0, 1'b0, 1'b1, 2'b10);
        check("R1 pulse-mode single", 64'(mode_out), 64'd2);
        set_mode(1'b0, 1'b1, 1'b1, 2'b11);
        check("R1 ddr wins over pulse-mode", 64'(mode_out), 64'd0);
        set_mode(1'b0, 1'b0, 1'b1, 2'b00);
        check("R1 no channel other", 64'(mode_out), 64'd3);
        set_mode(1'b0, 1'b0, 1'b0, 2'b11);
        check("R1 plain other", 64'(mode_out), 64'd3);
    endtask

    task automatic t_capture(input string req, input int per, input int offset);
        logic [63:0] exp;
        strobe_per = per;
        repeat (offset + 5) @(negedge clk);
        pulse_in = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        exp = m_ddr ? {1'b1, m_cnt[62:1], 1'(m_since & 1)} : {1'b1, m_cnt[62:0]};
        @(negedge clk);
        check("R7 still live before third edge", stamp_out, m_cnt);
        @(negedge clk);
        check(req, stamp_out, exp);
        repeat (12) @(negedge clk);
        check("R7 frozen while held", stamp_out, exp);
        pulse_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 held until third edge after fall", stamp_out, exp);
        @(negedge clk);
        check("R4 live resumes without lost time", stamp_out, m_cnt);
        repeat (3) @(negedge clk);
        check("R2 live counter keeps counting", stamp_out, m_cnt);
    endtask

    initial begin
        t_reset();
        t_modes();
        // single-channel DDR: step of two, refined low bit
        set_mode(1'b0, 1'b1, 1'b0, 2'b01);
        m_step = 2; m_ddr = 1'b1;
        t_capture("R5 ddr snapshot phase a", 2, 0);
        t_capture("R5 ddr snapshot phase b", 2, 1);
        // R3: long gap saturates the tick counter (odd parity 15)
        strobe_per = 0;
        repeat (25) @(negedge clk);
        t_capture("R3 saturated tick refines low bit", 0, 0);
        check("R3 model tick saturated", 64'(m_since), 64'(TICK_MAX));
        // per-sample modes: no refinement
        set_mode(1'b1, 1'b0, 1'b0, 2'b11);
        m_step = 1; m_ddr = 1'b0;
        t_capture("R6 dual snapshot", 1, 0);
        set_mode(1'b0, 1'b0, 1'b1, 2'b01);
        t_capture("R6 single snapshot sparse strobe", 3, 1);
        check("R2 counter advanced overall", 64'(m_cnt != 0), 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule